// File: doc/BRIEF.md
# Serial/Parallel Divider Configuration Loader

This block holds the configuration words of a clock synthesizer: a 9-bit feedback divider code M, a 2-bit output divider code N and a 2-bit test select T. The codes come from one of two sources. A wide set of parallel pins is passed through to M and N while an active-low parallel strobe is low, and frozen when the strobe rises. A three-wire serial port shifts a 14-bit frame into a shift register and commits it to M, N and T under a serial load strobe.

The block also drives a debug output whose source is picked by T: a constant low, the serial data line, a tap from the feedback divider or a tap from the synthesized clock. The serial clock and load lines are treated as slow, synchronous control inputs of one system clock. Rising edges of the serial clock are detected inside the block. The analog loop, the oscillator and the dividers are outside this block.

Top module: `divcfg_loader`

## Requirements
- R1: While rst_ni is low, t_o is 00 and the shift register is cleared to all zeros. At the first clock edge after reset is released, m_o and n_o take the values on par_m_i and par_n_i.
- R2: While par_load_ni is low, m_o and n_o take par_m_i and par_n_i at every clock edge, so an output is visible one clock after the pins are sampled.
- R3: While par_load_ni is high and ser_load_i stays low, a change on par_m_i or par_n_i has no effect on m_o and n_o. The values sampled last while the strobe was low are held.
- R4: While par_load_ni is high, each rising edge of ser_clk_i shifts ser_data_i into the 14-bit shift register, MSB first. After a full frame the register holds, from bit 13 down to bit 0: T1, T0, a null bit, N1, N0, M8 ... M0.
- R5: While ser_load_i is low, shifting does not change m_o, n_o or t_o.
- R6: The null bit of the frame (shift register bit 11) is discarded and never reaches m_o, n_o or t_o.
- R7: While ser_load_i is high and par_load_ni is high, m_o, n_o and t_o take the shift register fields (M from bits 8:0, N from bits 10:9, T from bits 13:12) at every clock edge. A rising edge of ser_clk_i in that state loads the newly shifted contents.
- R8: After ser_load_i falls, later serial shifting leaves m_o, n_o and t_o unchanged.
- R9: With par_load_ni high, test_o follows t_o: 00 drives 0, 01 drives ser_data_i, 10 drives fb_tap_i and 11 drives out_tap_i.
- R10: While par_load_ni is low, test_o is 0 whatever the value of t_o.
- R11: A low par_load_ni takes priority over a high ser_load_i. T is never changed by the parallel path.
- R12: While par_load_ni is low, edges on ser_clk_i do not change the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| par_m_i | input | 9 | Parallel feedback divider code |
| par_n_i | input | 2 | Parallel output divider code |
| par_load_ni | input | 1 | Parallel strobe; low passes pins through, rising freezes them |
| ser_clk_i | input | 1 | Serial shift clock, sampled by clk_i |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Serial commit strobe; high loads, falling holds |
| fb_tap_i | input | 1 | Feedback divider tap for the debug output |
| out_tap_i | input | 1 | Synthesized clock tap for the debug output |
| m_o | output | 9 | Active feedback divider code |
| n_o | output | 2 | Active output divider code |
| t_o | output | 2 | Active test select |
| test_o | output | 1 | Debug output |

## Verification
The assertions take for granted that every control input is synchronous to clk_i and that ser_clk_i stays low at reset release, so the first edge is not taken as a rising edge of the serial clock. The hold properties are armed only from the second clock after reset, because the first edge loads the parallel pins. The stimulus changes every input just after a falling edge of clk_i. It holds each ser_clk_i level for a full clock period, so each serial pulse makes exactly one detected rising edge. ser_load_i pulses last one period, or are held high for a whole frame on purpose.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int NULL_W  = 1;
  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;

  // Field order is the serial arrival order, MSB first.
  typedef struct packed {
    logic [T_W-1:0]    t;
    logic [NULL_W-1:0] nul;
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
  } frame_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_FB    = 2'b10,
    TSEL_OUT   = 2'b11
  } tsel_e;
endpackage

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         data_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] sr_next_o
);
  logic [W-1:0] sr_q;

  always_comb begin
    sr_next_o = sr_q;
    if (shift_i) sr_next_o = {sr_q[W-2:0], data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_next_o;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/divcfg_regs.sv
module divcfg_regs
  import divcfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           par_load_ni,
  input  logic           ser_load_i,
  input  frame_t         frame_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o
);
  logic           init_q;
  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic [T_W-1:0] t_q;
  logic           unused_null;

  assign unused_null = |frame_i.nul;

  // Parallel strobe wins over the serial strobe; T only comes from a frame.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      m_q    <= '0;
      n_q    <= '0;
      t_q    <= '0;
    end else if (init_q || !par_load_ni) begin
      init_q <= 1'b0;
      m_q    <= par_m_i;
      n_q    <= par_n_i;
    end else if (ser_load_i) begin
      m_q    <= frame_i.m;
      n_q    <= frame_i.n;
      t_q    <= frame_i.t;
    end
  end

  assign m_o = m_q;
  assign n_o = n_q;
  assign t_o = t_q;
endmodule

// File: rtl/divcfg_test_mux.sv
module divcfg_test_mux
  import divcfg_pkg::*;
(
  input  logic [T_W-1:0] sel_i,
  input  logic           par_mode_i,
  input  logic           sdata_i,
  input  logic           fb_tap_i,
  input  logic           out_tap_i,
  output logic           test_o
);
  tsel_e sel;
  assign sel = tsel_e'(sel_i);

  always_comb begin
    test_o = 1'b0;
    if (!par_mode_i) begin
      unique case (sel)
        TSEL_LOW:   test_o = 1'b0;
        TSEL_SDATA: test_o = sdata_i;
        TSEL_FB:    test_o = fb_tap_i;
        TSEL_OUT:   test_o = out_tap_i;
        default:    test_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           par_load_ni,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           fb_tap_i,
  input  logic           out_tap_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           test_o
);
  logic               sclk_rise;
  logic               shift_en;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_next;
  frame_t             frame_next;
  logic               unused_sr;

  divcfg_edge #(.W(1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ser_clk_i),
    .rise_o (sclk_rise)
  );

  assign shift_en = sclk_rise & par_load_ni;

  divcfg_shift #(.W(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift_en),
    .data_i    (ser_data_i),
    .sr_o      (sr_q),
    .sr_next_o (sr_next)
  );

  assign unused_sr  = |sr_q;
  // Load path sees the post-shift value so a held strobe tracks each bit.
  assign frame_next = frame_t'(sr_next);

  divcfg_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .par_m_i     (par_m_i),
    .par_n_i     (par_n_i),
    .par_load_ni (par_load_ni),
    .ser_load_i  (ser_load_i),
    .frame_i     (frame_next),
    .m_o         (m_o),
    .n_o         (n_o),
    .t_o         (t_o)
  );

  divcfg_test_mux u_mux (
    .sel_i      (t_o),
    .par_mode_i (~par_load_ni),
    .sdata_i    (ser_data_i),
    .fb_tap_i   (fb_tap_i),
    .out_tap_i  (out_tap_i),
    .test_o     (test_o)
  );
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk
  import divcfg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [M_W-1:0] par_m_i,
  input logic [N_W-1:0] par_n_i,
  input logic           par_load_ni,
  input logic           ser_data_i,
  input logic           ser_load_i,
  input logic           fb_tap_i,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [T_W-1:0] t_o,
  input logic           test_o
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) assert_reset_t_clear_R1: assert (t_o == '0);
  end

  assert_par_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !par_load_ni |=> (m_o == $past(par_m_i)) && (n_o == $past(par_n_i)));

  assert_serial_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && par_load_ni && !ser_load_i |=> $stable(m_o) && $stable(n_o) && $stable(t_o));

  assert_t_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_load_ni |=> $stable(t_o));

  assert_test_low_par_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_load_ni |-> !test_o);

  assert_test_sdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_load_ni && (t_o == 2'b01) |-> test_o == ser_data_i);

  assert_test_fb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_load_ni && (t_o == 2'b10) |-> test_o == fb_tap_i);

  assert_test_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_load_ni && (t_o == 2'b00) |-> !test_o);
endmodule

bind divcfg_loader divcfg_loader_chk chk_i (.*);

// File: tb/divcfg_loader_tb_top.sv
module divcfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] pm;
  logic [1:0] pn;
  logic       pload_n, sclk, sdata, sload, fb, outt;
  logic [8:0] m;
  logic [1:0] n, t;
  logic       test;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [13:0] model_sr = '0;

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [1:0] t;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  divcfg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .par_m_i(pm), .par_n_i(pn),
    .par_load_ni(pload_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_load_i(sload), .fb_tap_i(fb), .out_tap_i(outt),
    .m_o(m), .n_o(n), .t_o(t), .test_o(test)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(logic [8:0] em, logic [1:0] en, logic [1:0] et, string tag);
    exp_t e;
    e.m = em; e.n = en; e.t = et; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_sr(string tag);
    push(model_sr[8:0], model_sr[10:9], model_sr[13:12], tag);
  endtask

  // One serial frame, MSB first; model follows R4 and R12.
  task automatic send_bits(logic [13:0] f, string tag);
    for (int i = 13; i >= 0; i--) begin
      sdata = f[i];
      tick();
      sclk = 1'b1;
      tick();
      sclk = 1'b0;
      if (pload_n) model_sr = {model_sr[12:0], f[i]};
      if (sload && pload_n) push_sr(tag);
    end
  endtask

  task automatic sload_pulse();
    sload = 1'b1;
    tick();
    sload = 1'b0;
    tick();
  endtask

  task automatic chk_test(logic e, string tag);
    #1;
    check(test === e, tag, {31'd0, test}, {31'd0, e});
  endtask

  // Monitor: compare queued expectations just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(m === e.m, {e.tag, " m"}, {23'd0, m}, {23'd0, e.m});
        check(n === e.n, {e.tag, " n"}, {30'd0, n}, {30'd0, e.n});
        check(t === e.t, {e.tag, " t"}, {30'd0, t}, {30'd0, e.t});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pload_n = 1; sload = 0; sclk = 0; sdata = 0;
    pm = 9'h1a5; pn = 2'd2; fb = 0; outt = 0;
    repeat (3) tick();
    #1;
    check(t === 2'b00, "R1 t in reset", {30'd0, t}, 32'd0);
    rst_n = 1;
    tick();
    push(9'h1a5, 2'd2, 2'b00, "R1 pins at first edge");

    pm = 9'h033; pn = 2'd1;
    tick(); tick();
    push(9'h1a5, 2'd2, 2'b00, "R3 pins ignored");

    sload_pulse();
    push(9'h000, 2'd0, 2'b00, "R1 shift reg cleared");

    pload_n = 0;
    chk_test(1'b0, "R10 par mode");
    tick();
    push(9'h033, 2'd1, 2'b00, "R2 pass through");
    pm = 9'h1ff; pn = 2'd3;
    tick();
    push(9'h1ff, 2'd3, 2'b00, "R2 pass through 2");

    pload_n = 1;
    tick();
    pm = 9'h055; pn = 2'd0;
    tick(); tick();
    push(9'h1ff, 2'd3, 2'b00, "R3 latched");

    send_bits({2'b01, 1'b0, 2'b10, 9'h0b7}, "R5");
    tick();
    push(9'h1ff, 2'd3, 2'b00, "R5 shift without load");
    sload_pulse();
    push(9'h0b7, 2'd2, 2'b01, "R4 frame commit");
    sdata = 1; chk_test(1'b1, "R9 sel 01 high");
    sdata = 0; chk_test(1'b0, "R9 sel 01 low");

    send_bits({2'b10, 1'b1, 2'b01, 9'h12c}, "R6");
    sload_pulse();
    push(9'h12c, 2'd1, 2'b10, "R6 null discarded");
    fb = 1; chk_test(1'b1, "R9 sel 10 high");
    fb = 0; chk_test(1'b0, "R9 sel 10 low");

    send_bits({2'b11, 1'b1, 2'b00, 9'h0f0}, "R4");
    sload_pulse();
    push(9'h0f0, 2'd0, 2'b11, "R4 frame 3");
    outt = 1; chk_test(1'b1, "R9 sel 11 high");

    pload_n = 0;
    chk_test(1'b0, "R10 test forced low");
    tick();
    push(9'h055, 2'd0, 2'b11, "R11 T kept in par mode");
    outt = 0;

    send_bits({2'b00, 1'b0, 2'b11, 9'h1c3}, "R12");
    pload_n = 1;
    tick();
    sload_pulse();
    push_sr("R12 shift reg untouched");

    sload = 1;
    tick();
    push_sr("R7 load on rise");
    send_bits({2'b00, 1'b1, 2'b10, 9'h155}, "R7 transparent");
    sload = 0;
    tick();
    send_bits({2'b01, 1'b0, 2'b01, 9'h0aa}, "R8");
    tick();
    push(9'h155, 2'd2, 2'b00, "R8 held after fall");
    sdata = 1; chk_test(1'b0, "R9 sel 00");
    sdata = 0;

    pm = 9'h111; pn = 2'd2;
    sload = 1; pload_n = 0;
    tick(); tick();
    push(9'h111, 2'd2, 2'b00, "R11 parallel wins");
    sload = 0;
    tick(); tick(); tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule